// File: doc/BRIEF.md
# PLL Divider Pair with Status Selector

This block holds the digital counters of an integer-N synthesizer. A reference divider counts reference ticks. A feedback divider counts feedback ticks. Each divide value is a plain binary number and is used as the divide ratio directly. Both dividers run in one system clock domain. Each reference or feedback edge arrives as a one-cycle tick qualifier. Each divider emits a one-cycle terminal-count pulse and keeps a toggle that gives a half-rate square wave with 50% duty.

A lock detector pairs the terminal-count events of the two dividers. A pair counts as good when the two events fall within two reference ticks of each other. Lock is declared after eight good pairs in a row, and it drops at the first bad pair. For high comparison rates, a prescale mode feeds only every fourth terminal count of each divider to the detector. A 4-bit selector picks what the single status pin shows:

- high impedance
- a constant level
- lock, in either polarity
- one of the half-rate divider waves

Every unsupported code drives the pin low.

Top module: `pll_div_status`

## Requirements
- R1: With `refDivisor` = D (D ≥ 1), `refDivPulse` is high for exactly one cycle after every D-th `refTick`. The pulse appears in the cycle that follows the clock edge at which that tick was sampled. It is low at all other times.
- R2: `fbDivPulse` behaves in the same way on `fbTick`, with the 18-bit `fbDivisor` (for example 760) used as the ratio.
- R3: A divisor of zero has three effects. The matching counter is held cleared. Its pulse stays low. `statusPin` is driven low (`statusDrive`=1, `statusPin`=0) whatever the selector code.
- R4: A synchronous active-high `rst` clears both counters, both half-rate toggles, the prescalers and the lock state. After reset both pulses are low.
- R5: Selector code 0 releases the pin (`statusDrive`=0). Code 1 drives it high. Code 2 drives it low.
- R6: Code 3 drives the lock state onto the pin. Code 4 drives its inverse.
- R7: Codes 5, 6, 7, 8, 10 and 12 to 15 drive the pin low.
- R8: Code 9 shows the feedback half-rate toggle and code 11 shows the reference one. Each toggle is low after reset and flips together with every terminal-count pulse of its divider.
- R9: A pair is good when both events come in the same cycle, or when the second event comes while the count of reference ticks since the first event is no more than 2 (ticks in the cycle of the second event included). Lock sets at the edge that registers the eighth good pair in a row.
- R10: Any of three cases is a bad pair: the tick count since a lone event exceeds 2, an event matches too late, or a second event of the same side arrives while one is pending. A bad pair clears lock and the run count at once.
- R11: With `lockPrescale`=1, only every fourth terminal count of each divider takes part in R9/R10 (the 4th, 8th, … since reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| refTick | input | 1 | One-cycle qualifier per reference edge |
| fbTick | input | 1 | One-cycle qualifier per feedback edge |
| refDivisor | input | 12 | Reference divide ratio (0 invalid) |
| fbDivisor | input | 18 | Feedback divide ratio (0 invalid) |
| lockPrescale | input | 1 | Feed every fourth terminal count to the lock detector |
| statusSel | input | 4 | Status pin selector code |
| refDivPulse | output | 1 | Reference terminal-count pulse |
| fbDivPulse | output | 1 | Feedback terminal-count pulse |
| statusPin | output | 1 | Status pin value |
| statusDrive | output | 1 | Status pin output enable (0 = high impedance) |

## Verification
The bench targets four corner cases:

- **Window edge.** A feedback stream shifted by one tick must keep lock, and a shift of four ticks must lose it. A design with an off-by-one window would lock on skewed clocks or drop a clean lock.
- **Prescale.** A design that ignores prescale would lock several times too early.
- **Zero divisor.** A zero divisor must silence its pulse and force the pin low. A design that got this wrong would let the counter wrap through an all-ones ratio.
- **Selector sweep.** Every selector code is swept, so a reserved code that leaks a divider wave or releases the pin is caught.

A random tick run with co-prime ratios exercises the lone-event timeout and the repeated-same-side case.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

  localparam logic [3:0] SEL_HIZ      = 4'd0;
  localparam logic [3:0] SEL_HIGH     = 4'd1;
  localparam logic [3:0] SEL_LOW      = 4'd2;
  localparam logic [3:0] SEL_LOCK_HI  = 4'd3;
  localparam logic [3:0] SEL_LOCK_LO  = 4'd4;
  localparam logic [3:0] SEL_FB_HALF  = 4'd9;
  localparam logic [3:0] SEL_REF_HALF = 4'd11;

  typedef struct packed {
    logic rTc;
    logic nTc;
    logic rHalf;
    logic nHalf;
    logic rZero;
    logic nZero;
  } divStrobes_t;

endpackage

// File: rtl/pdiv_counter.sv
module pdiv_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] divVal,
  output logic         zero,
  output logic         tc,
  output logic         half
);

  logic [W-1:0] cnt;
  logic         atLast;

  assign zero   = (divVal == '0);
  assign atLast = (cnt >= divVal - W'(1));

  always_ff @(posedge clk) begin
    if (rst || zero) begin
      cnt  <= '0;
      tc   <= 1'b0;
      half <= 1'b0;
    end else if (tick) begin
      if (atLast) begin
        cnt  <= '0;
        tc   <= 1'b1;
        half <= ~half;
      end else begin
        cnt <= cnt + W'(1);
        tc  <= 1'b0;
      end
    end else begin
      tc <= 1'b0;
    end
  end

  AST_TC_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    tc |-> $past(tick)); // R1
  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (rst)
    $past(zero) |-> !tc); // R3
  AST_HALF_MOVES_WITH_TC: assert property (@(posedge clk) disable iff (rst)
    (half != $past(half)) |-> (tc || $past(zero))); // R8

endmodule

// File: rtl/pdiv_datapath.sv
module pdiv_datapath
  import pdiv_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int FB_W  = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             refTick,
  input  logic             fbTick,
  input  logic [REF_W-1:0] refDivisor,
  input  logic [FB_W-1:0]  fbDivisor,
  output divStrobes_t      strobes
);

  logic rZero, rTc, rHalf;
  logic nZero, nTc, nHalf;

  pdiv_counter #(.W(REF_W)) u_refCnt (
    .clk(clk), .rst(rst), .tick(refTick), .divVal(refDivisor),
    .zero(rZero), .tc(rTc), .half(rHalf)
  );

  pdiv_counter #(.W(FB_W)) u_fbCnt (
    .clk(clk), .rst(rst), .tick(fbTick), .divVal(fbDivisor),
    .zero(nZero), .tc(nTc), .half(nHalf)
  );

  always_comb begin
    strobes.rTc   = rTc;
    strobes.nTc   = nTc;
    strobes.rHalf = rHalf;
    strobes.nHalf = nHalf;
    strobes.rZero = rZero;
    strobes.nZero = nZero;
  end

  AST_FB_TC_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    nTc |-> $past(fbTick)); // R2

endmodule

// File: rtl/pdiv_lock_ctrl.sv
module pdiv_lock_ctrl
  import pdiv_pkg::*;
#(
  parameter int LOCK_HITS = 8,
  parameter int WINDOW    = 2,
  parameter int PRESCALE  = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        refTick,
  input  logic        lockPrescale,
  input  divStrobes_t strobes,
  input  logic [3:0]  statusSel,
  output logic        statusPin,
  output logic        statusDrive
);

  localparam int PRE_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int AGE_W  = $clog2(WINDOW + 2);
  localparam int GOOD_W = (LOCK_HITS > 1) ? $clog2(LOCK_HITS) : 1;

  logic [PRE_W-1:0]  preR, preN;
  logic [AGE_W-1:0]  age, ageInc, ageNext;
  logic [GOOD_W-1:0] good;
  logic              pendR, pendN, pendRNext, pendNNext;
  logic              evR, evN, hit, miss, locked;

  // Prescaler: selects which terminal counts reach the comparator
  assign evR = strobes.rTc && (!lockPrescale || preR == PRE_W'(PRESCALE - 1));
  assign evN = strobes.nTc && (!lockPrescale || preN == PRE_W'(PRESCALE - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      preR <= '0;
      preN <= '0;
    end else begin
      if (strobes.rTc) preR <= (preR == PRE_W'(PRESCALE - 1)) ? '0 : preR + PRE_W'(1);
      if (strobes.nTc) preN <= (preN == PRE_W'(PRESCALE - 1)) ? '0 : preN + PRE_W'(1);
    end
  end

  // Pairing of events within the window
  assign ageInc = age + AGE_W'(refTick);

  always_comb begin
    hit       = 1'b0;
    miss      = 1'b0;
    pendRNext = pendR;
    pendNNext = pendN;
    ageNext   = age;
    if (evR && evN) begin
      hit       = 1'b1;
      pendRNext = 1'b0;
      pendNNext = 1'b0;
    end else if (evR) begin
      if (pendN) begin
        if (ageInc <= AGE_W'(WINDOW)) hit = 1'b1;
        else miss = 1'b1;
        pendNNext = 1'b0;
      end else if (pendR) begin
        miss    = 1'b1;
        ageNext = '0;
      end else begin
        pendRNext = 1'b1;
        ageNext   = '0;
      end
    end else if (evN) begin
      if (pendR) begin
        if (ageInc <= AGE_W'(WINDOW)) hit = 1'b1;
        else miss = 1'b1;
        pendRNext = 1'b0;
      end else if (pendN) begin
        miss    = 1'b1;
        ageNext = '0;
      end else begin
        pendNNext = 1'b1;
        ageNext   = '0;
      end
    end else if (pendR || pendN) begin
      if (ageInc > AGE_W'(WINDOW)) begin
        miss      = 1'b1;
        pendRNext = 1'b0;
        pendNNext = 1'b0;
        ageNext   = '0;
      end else begin
        ageNext = ageInc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendR  <= 1'b0;
      pendN  <= 1'b0;
      age    <= '0;
      good   <= '0;
      locked <= 1'b0;
    end else begin
      pendR <= pendRNext;
      pendN <= pendNNext;
      age   <= ageNext;
      if (miss) begin
        good   <= '0;
        locked <= 1'b0;
      end else if (hit) begin
        if (good == GOOD_W'(LOCK_HITS - 1)) locked <= 1'b1;
        else good <= good + GOOD_W'(1);
      end
    end
  end

  // Status pin selector
  always_comb begin
    statusDrive = 1'b1;
    statusPin   = 1'b0;
    if (!(strobes.rZero || strobes.nZero)) begin
      case (statusSel)
        SEL_HIZ:      statusDrive = 1'b0;
        SEL_HIGH:     statusPin   = 1'b1;
        SEL_LOW:      statusPin   = 1'b0;
        SEL_LOCK_HI:  statusPin   = locked;
        SEL_LOCK_LO:  statusPin   = ~locked;
        SEL_FB_HALF:  statusPin   = strobes.nHalf;
        SEL_REF_HALF: statusPin   = strobes.rHalf;
        default:      statusPin   = 1'b0;
      endcase
    end
  end

  AST_LOCK_RISE_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(hit)); // R9
  AST_LOCK_FALL_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(miss)); // R10
  AST_ONE_SIDE_PENDING: assert property (@(posedge clk) disable iff (rst)
    !(pendR && pendN)); // R9
  AST_HIZ_ONLY_CODE0: assert property (@(posedge clk) disable iff (rst)
    !statusDrive |-> (statusSel == SEL_HIZ)); // R5
  AST_ZERO_DIV_LOW: assert property (@(posedge clk) disable iff (rst)
    (strobes.rZero || strobes.nZero) |-> (statusDrive && !statusPin)); // R3
  AST_RESERVED_LOW: assert property (@(posedge clk) disable iff (rst)
    (statusSel inside {4'd5, 4'd6, 4'd7, 4'd8, 4'd10, [4'd12:4'd15]})
      |-> (statusDrive && !statusPin)); // R7

endmodule

// File: rtl/pll_div_status.sv
module pll_div_status
  import pdiv_pkg::*;
#(
  parameter int REF_W     = 12,
  parameter int FB_W      = 18,
  parameter int LOCK_HITS = 8,
  parameter int WINDOW    = 2,
  parameter int PRESCALE  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             refTick,
  input  logic             fbTick,
  input  logic [REF_W-1:0] refDivisor,
  input  logic [FB_W-1:0]  fbDivisor,
  input  logic             lockPrescale,
  input  logic [3:0]       statusSel,
  output logic             refDivPulse,
  output logic             fbDivPulse,
  output logic             statusPin,
  output logic             statusDrive
);

  divStrobes_t strobes;

  pdiv_datapath #(.REF_W(REF_W), .FB_W(FB_W)) u_dp (
    .clk(clk), .rst(rst), .refTick(refTick), .fbTick(fbTick),
    .refDivisor(refDivisor), .fbDivisor(fbDivisor), .strobes(strobes)
  );

  pdiv_lock_ctrl #(.LOCK_HITS(LOCK_HITS), .WINDOW(WINDOW), .PRESCALE(PRESCALE)) u_ctrl (
    .clk(clk), .rst(rst), .refTick(refTick), .lockPrescale(lockPrescale),
    .strobes(strobes), .statusSel(statusSel),
    .statusPin(statusPin), .statusDrive(statusDrive)
  );

  assign refDivPulse = strobes.rTc;
  assign fbDivPulse  = strobes.nTc;

  AST_RST_CLEARS_PULSES: assert property (@(posedge clk)
    $past(rst) |-> (!refDivPulse && !fbDivPulse)); // R4

endmodule

// File: tb/pll_div_status_tb.sv
`timescale 1ns/1ps
module pll_div_status_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        refTick = 1'b0, fbTick = 1'b0;
  logic [11:0] refDivisor = 12'd10;
  logic [17:0] fbDivisor  = 18'd10;
  logic        lockPrescale = 1'b0;
  logic [3:0]  statusSel = 4'd0;
  logic        refDivPulse, fbDivPulse, statusPin, statusDrive;

  int nTests = 0, nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pll_div_status u_dut (
    .clk(clk), .rst(rst), .refTick(refTick), .fbTick(fbTick),
    .refDivisor(refDivisor), .fbDivisor(fbDivisor), .lockPrescale(lockPrescale),
    .statusSel(statusSel), .refDivPulse(refDivPulse), .fbDivPulse(fbDivPulse),
    .statusPin(statusPin), .statusDrive(statusDrive)
  );

  // Tick generator: periodic with optional one-shot feedback drops, or random
  int refEvery = 1, fbEvery = 1, fbDrop = 0, refPh = 0, fbPh = 0;
  bit randMode = 0;
  always @(posedge clk) begin
    #1;
    if (randMode) begin
      refTick = ($urandom % 2) == 1;
      fbTick  = ($urandom % 3) != 0;
    end else begin
      refPh++;
      fbPh++;
      refTick = (refPh % refEvery) == 0;
      if ((fbPh % fbEvery) == 0) begin
        if (fbDrop > 0) begin
          fbDrop--;
          fbTick = 1'b0;
        end else fbTick = 1'b1;
      end else fbTick = 1'b0;
    end
  end

  // Behavioural reference model
  int mRc, mNc, mPreR, mPreN, mAge, mGood, ageSum;
  bit mRTc, mNTc, mRHalf, mNHalf, mPendR, mPendN, mLock, eR, eN, mHit, mMiss;
  always @(posedge clk) begin
    if (rst) begin
      mRc = 0; mNc = 0; mPreR = 0; mPreN = 0; mAge = 0; mGood = 0;
      mRTc = 0; mNTc = 0; mRHalf = 0; mNHalf = 0; mPendR = 0; mPendN = 0; mLock = 0;
    end else begin
      eR = mRTc && (!lockPrescale || mPreR == 3);
      eN = mNTc && (!lockPrescale || mPreN == 3);
      if (mRTc) mPreR = (mPreR + 1) % 4;
      if (mNTc) mPreN = (mPreN + 1) % 4;
      ageSum = mAge + (refTick ? 1 : 0);
      mHit = 0; mMiss = 0;
      if (eR && eN) begin mHit = 1; mPendR = 0; mPendN = 0; end
      else if (eR) begin
        if (mPendN) begin if (ageSum <= 2) mHit = 1; else mMiss = 1; mPendN = 0; end
        else if (mPendR) begin mMiss = 1; mAge = 0; end
        else begin mPendR = 1; mAge = 0; end
      end else if (eN) begin
        if (mPendR) begin if (ageSum <= 2) mHit = 1; else mMiss = 1; mPendR = 0; end
        else if (mPendN) begin mMiss = 1; mAge = 0; end
        else begin mPendN = 1; mAge = 0; end
      end else if (mPendR || mPendN) begin
        if (ageSum > 2) begin mMiss = 1; mPendR = 0; mPendN = 0; mAge = 0; end
        else mAge = ageSum;
      end
      if (mMiss) begin mGood = 0; mLock = 0; end
      else if (mHit) begin if (mGood == 7) mLock = 1; else mGood++; end
      if (refDivisor == 0) begin mRc = 0; mRTc = 0; mRHalf = 0; end
      else if (refTick) begin
        if (mRc >= int'(refDivisor) - 1) begin mRc = 0; mRTc = 1; mRHalf = !mRHalf; end
        else begin mRc++; mRTc = 0; end
      end else mRTc = 0;
      if (fbDivisor == 0) begin mNc = 0; mNTc = 0; mNHalf = 0; end
      else if (fbTick) begin
        if (mNc >= int'(fbDivisor) - 1) begin mNc = 0; mNTc = 1; mNHalf = !mNHalf; end
        else begin mNc++; mNTc = 0; end
      end else mNTc = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  bit started = 0;
  bit expDrive, expPin;
  string stReq;
  always @(negedge clk) begin
    if (started) begin
      check(refDivPulse == mRTc, "R1 refDivPulse", refDivPulse, mRTc);
      check(fbDivPulse == mNTc, "R2 fbDivPulse", fbDivPulse, mNTc);
      expDrive = 1; expPin = 0;
      if (refDivisor == 0 || fbDivisor == 0) stReq = "R3 status";
      else begin
        case (statusSel)
          4'd0: begin expDrive = 0; stReq = "R5 status"; end
          4'd1: begin expPin = 1; stReq = "R5 status"; end
          4'd2: stReq = "R5 status";
          4'd3: begin expPin = mLock; stReq = "R6/R9 status"; end
          4'd4: begin expPin = !mLock; stReq = "R6/R10 status"; end
          4'd9: begin expPin = mNHalf; stReq = "R8 status"; end
          4'd11: begin expPin = mRHalf; stReq = "R8 status"; end
          default: stReq = "R7 status";
        endcase
      end
      check(statusDrive == expDrive, {stReq, " drive"}, statusDrive, expDrive);
      if (expDrive) check(statusPin == expPin, stReq, statusPin, expPin);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sample_status(input string req, input bit expP);
    @(negedge clk);
    check(statusDrive == 1'b1 && statusPin == expP, req, statusPin, expP);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(4);
    rst = 1'b0;
  endtask

  initial begin
    cyc(1);
    started = 1;
    cyc(3);
    // R4: reset state
    @(negedge clk);
    check(!refDivPulse && !fbDivPulse, "R4 pulses low in reset", refDivPulse + fbDivPulse, 0);
    check(!statusDrive, "R5 code 0 high impedance", statusDrive, 0);
    rst = 1'b0;

    // Aligned streams, equal ratios: lock
    statusSel = 4'd3;
    cyc(150);
    sample_status("R9 lock after aligned pairs", 1'b1);
    statusSel = 4'd4;
    sample_status("R6 inverted lock", 1'b0);
    statusSel = 4'd9;  cyc(40);
    statusSel = 4'd11; cyc(40);
    for (int s = 0; s < 16; s++) begin
      statusSel = 4'(s);
      cyc(3);
      if (s inside {5, 6, 7, 8, 10, 12, 13, 14, 15})
        sample_status("R7 reserved code low", 1'b0);
    end
    statusSel = 4'd1;
    sample_status("R5 constant high", 1'b1);

    // Skew of one tick keeps lock, skew of four loses it
    statusSel = 4'd3;
    fbDrop = 1; cyc(60);
    sample_status("R9 one-tick skew keeps lock", 1'b1);
    fbDrop = 4; cyc(30);
    sample_status("R10 four-tick skew clears lock", 1'b0);
    cyc(100);
    sample_status("R10 stays unlocked", 1'b0);

    // Zero divisors
    refDivisor = 12'd0; statusSel = 4'd1; cyc(30);
    sample_status("R3 zero ref divisor forces low", 1'b0);
    check(!refDivPulse, "R3 zero ref divisor silent", refDivPulse, 0);
    refDivisor = 12'd10; fbDivisor = 18'd0; statusSel = 4'd9; cyc(30);
    sample_status("R3 zero fb divisor forces low", 1'b0);
    fbDivisor = 18'd10;

    // Prescale: every fourth terminal count compared
    lockPrescale = 1'b1; refDivisor = 12'd3; fbDivisor = 18'd3;
    do_reset();
    statusSel = 4'd3;
    cyc(60);
    sample_status("R11 prescale delays lock", 1'b0);
    cyc(90);
    sample_status("R11 prescale eventually locks", 1'b1);

    // Slow reference, large feedback ratio 760
    lockPrescale = 1'b0; refDivisor = 12'd10; fbDivisor = 18'd760;
    refEvery = 76; fbEvery = 1;
    do_reset();
    cyc(7000);
    sample_status("R2 R9 lock with ratio 760", 1'b1);

    // Random tick streams with unrelated ratios
    refDivisor = 12'd5; fbDivisor = 18'd7;
    do_reset();
    randMode = 1;
    for (int k = 0; k < 3000; k++) begin
      statusSel = 4'((k / 50) % 16);
      cyc(1);
    end
    randMode = 0;

    // R4: synchronous reset mid-run clears toggles and lock
    refEvery = 1;
    statusSel = 4'd11;
    do_reset();
    sample_status("R4 R8 half toggle cleared by reset", 1'b0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule